// File: doc/BRIEF.md
# Subroutine Return Stack in Data RAM

This block is the call and return controller of a small microcontroller core. It keeps return addresses in the general data RAM instead of in dedicated stack registers. Each of the eight stack levels takes a pair of adjacent bytes between byte 8 and byte 23. A level holds the 12-bit return address together with the upper nibble of the status word.

A 3-bit stack pointer chooses the level. It always names the pair that the next push will fill. The pointer wraps modulo eight in both directions and raises no error flag.

Three events push a level and load a new program counter:
- a call, which takes its low eleven bits from the target input and bit 11 from a memory-bank flag;
- an external interrupt entry, which jumps to address 3;
- a timer interrupt entry, which jumps to address 7.

A return pops a level and restores both the program counter and the status nibble. The same RAM is served by an ordinary byte-wide data port, so unused stack bytes stay normal scratch storage.

Top module: `ret_stack_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, pc_o is 0, sp_o is 0 and psw_hi_o is 0, and the memory-bank flag is cleared.
- R2: An accepted call loads pc_o with {bank flag, target_i[10:0]} and increments sp_o by one. Both changes are visible after the clock edge that samples the call.
- R3: Every push writes two bytes. Byte 8+2*sp receives pc_i[7:0]. Byte 9+2*sp receives pc_i[11:8] in bits 3:0 and psw_hi_i in bits 7:4. Here sp is the pointer value before the push.
- R4: An accepted external interrupt loads pc_o with 3 and an accepted timer interrupt loads pc_o with 7, with bit 11 cleared. Both push the return address in the same way as a call.
- R5: A return takes two cycles. The first edge decrements sp_o and reads the pair at the new pointer. The second edge loads pc_o from that pair (bits 11:8 from the odd byte's low nibble) and loads psw_hi_o from the odd byte's high nibble.
- R6: The pointer wraps modulo 8. A push at sp 7 fills bytes 22 and 23 and leaves sp 0. A return at sp 0 reads bytes 22 and 23 and leaves sp 7.
- R7: When several strobes arrive in one cycle, the priority is external interrupt first, then timer interrupt, then call, then return. All strobes in the second cycle of a return are ignored and leave sp_o and pc_o as the return sets them.
- R8: bank_set_i sets the memory-bank flag and bank_clr_i clears it. If both are high, clear wins. A change affects calls from the next cycle on, and never affects interrupt entries or returns.
- R9: A data-port write to any byte always takes effect, stack bytes included. dp_rdata_o shows the addressed byte one cycle after the address, with the value from before any write in that cycle. If a push and a data write hit the same byte in one cycle, the push value is kept.
- R10: psw_hi_o changes only at the edge that ends a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Call strobe |
| irq_ext_i | input | 1 | External interrupt entry strobe |
| irq_tmr_i | input | 1 | Timer interrupt entry strobe |
| ret_i | input | 1 | Return strobe |
| target_i | input | 11 | Call target, address bits 10:0 |
| pc_i | input | 12 | Return address to save on a push |
| psw_hi_i | input | 4 | Status bits 7:4 to save on a push |
| bank_set_i | input | 1 | Set the memory-bank flag |
| bank_clr_i | input | 1 | Clear the memory-bank flag |
| dp_we_i | input | 1 | Data-port write enable |
| dp_addr_i | input | 6 | Data-port byte address |
| dp_wdata_i | input | 8 | Data-port write data |
| dp_rdata_o | output | 8 | Data-port read data, one cycle after the address |
| pc_o | output | 12 | Next program counter |
| psw_hi_o | output | 4 | Restored status bits 7:4 |
| sp_o | output | 3 | Stack pointer |

## Verification
Timing of the results:
- After a call or an interrupt entry, the new pc_o and sp_o are due one edge after the strobe, and the two pushed bytes can be read through the data port from the following cycle.
- After a return, sp_o is due one edge after the strobe, while pc_o and psw_hi_o are due at the second edge.
- dp_rdata_o is due one edge after its address.

The bench drives every input at the falling edge and advances a reference model by exactly one edge. It compares all outputs at the next falling edge. The model holds the return's read in a capture stage, so the restore lands on the second compare, as R5 requires.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_EXT,
    OP_TMR,
    OP_CALL,
    OP_RET
  } op_e;

  function automatic logic is_push(op_e op);
    return (op == OP_EXT) || (op == OP_TMR) || (op == OP_CALL);
  endfunction

endpackage

// File: rtl/rs_arb.sv
// Strobe arbitration and the second-cycle marker of a return.
module rs_arb
  import ret_stack_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ext_i,
  input  logic tmr_i,
  input  logic call_i,
  input  logic ret_i,
  output op_e  op_o,
  output logic busy_q
);

  always_comb begin
    op_o = OP_NONE;
    if (!busy_q) begin
      if (ext_i)       op_o = OP_EXT;
      else if (tmr_i)  op_o = OP_TMR;
      else if (call_i) op_o = OP_CALL;
      else if (ret_i)  op_o = OP_RET;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= (op_o == OP_RET);
  end

endmodule

// File: rtl/rs_ptr.sv
// Wrapping stack pointer: names the slot that the next push fills.
module rs_ptr #(
  parameter int SP_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc_i,
  input  logic            dec_i,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] sp_dn
);

  assign sp_dn = sp_q - SP_W'(1);

  always_ff @(posedge clk) begin
    if (rst)        sp_q <= '0;
    else if (inc_i) sp_q <= sp_q + SP_W'(1);
    else if (dec_i) sp_q <= sp_dn;
  end

endmodule

// File: rtl/rs_bank.sv
// One byte lane of the data RAM: two ports, registered read-first outputs.
// Port A (stack) is written after port B, so A keeps a same-row collision.
module rs_bank #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);

  localparam int ROWS = 2 ** AW;

  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
  end

endmodule

// File: rtl/rs_pcreg.sv
// Program counter, restored status nibble and memory-bank flag.
module rs_pcreg
  import ret_stack_pkg::*;
#(
  parameter int PC_W    = 12,
  parameter int DW      = 8,
  parameter int PSWH_W  = 4,
  parameter int VEC_EXT = 3,
  parameter int VEC_TMR = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op_i,
  input  logic              restore_i,
  input  logic              bank_set_i,
  input  logic              bank_clr_i,
  input  logic [PC_W-2:0]   target_i,
  input  logic [DW-1:0]     rd_lo_i,
  input  logic [DW-1:0]     rd_hi_i,
  output logic [PC_W-1:0]   pc_q,
  output logic [PSWH_W-1:0] psw_q
);

  localparam int HI_W = PC_W - DW;

  logic bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      psw_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      if (bank_clr_i)      bank_q <= 1'b0;
      else if (bank_set_i) bank_q <= 1'b1;
      if (restore_i) begin
        pc_q  <= {rd_hi_i[HI_W-1:0], rd_lo_i};
        psw_q <= rd_hi_i[DW-1:HI_W];
      end else begin
        case (op_i)
          OP_EXT:  pc_q <= PC_W'(VEC_EXT);
          OP_TMR:  pc_q <= PC_W'(VEC_TMR);
          OP_CALL: pc_q <= {bank_q, target_i};
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ret_stack_ctrl.sv
// Call/return controller keeping its stack in paired data RAM bytes.
module ret_stack_ctrl
  import ret_stack_pkg::*;
#(
  parameter int PC_W      = 12,
  parameter int DATA_W    = 8,
  parameter int PSWH_W    = 4,
  parameter int RAM_BYTES = 64,
  parameter int STK_BASE  = 8,
  parameter int LEVELS    = 8,
  parameter int VEC_EXT   = 3,
  parameter int VEC_TMR   = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         call_i,
  input  logic                         irq_ext_i,
  input  logic                         irq_tmr_i,
  input  logic                         ret_i,
  input  logic [PC_W-2:0]              target_i,
  input  logic [PC_W-1:0]              pc_i,
  input  logic [PSWH_W-1:0]            psw_hi_i,
  input  logic                         bank_set_i,
  input  logic                         bank_clr_i,
  input  logic                         dp_we_i,
  input  logic [$clog2(RAM_BYTES)-1:0] dp_addr_i,
  input  logic [DATA_W-1:0]            dp_wdata_i,
  output logic [DATA_W-1:0]            dp_rdata_o,
  output logic [PC_W-1:0]              pc_o,
  output logic [PSWH_W-1:0]            psw_hi_o,
  output logic [$clog2(LEVELS)-1:0]    sp_o
);

  localparam int ADDR_W  = $clog2(RAM_BYTES);
  localparam int ROW_W   = ADDR_W - 1;
  localparam int SP_W    = $clog2(LEVELS);
  localparam int STK_ROW = STK_BASE / 2;

  op_e              op;
  logic             busy_q;
  logic             push;
  logic [SP_W-1:0]  sp_q;
  logic [SP_W-1:0]  sp_dn;
  logic [ROW_W-1:0] stk_row;
  logic             sel_q;
  logic [DATA_W-1:0] wd     [2];
  logic [DATA_W-1:0] stk_rd [2];
  logic [DATA_W-1:0] dp_rd  [2];

  rs_arb u_arb (
    .clk    (clk),
    .rst    (rst),
    .ext_i  (irq_ext_i),
    .tmr_i  (irq_tmr_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .op_o   (op),
    .busy_q (busy_q)
  );

  assign push = is_push(op);

  rs_ptr #(.SP_W(SP_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .inc_i (push),
    .dec_i (op == OP_RET),
    .sp_q  (sp_q),
    .sp_dn (sp_dn)
  );

  // A push uses the current slot; a return reads the slot below it.
  assign stk_row = ROW_W'(STK_ROW) + ROW_W'(push ? sp_q : sp_dn);

  assign wd[0] = pc_i[DATA_W-1:0];
  assign wd[1] = {psw_hi_i, pc_i[PC_W-1:DATA_W]};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    rs_bank #(.AW(ROW_W), .DW(DATA_W)) u_bank (
      .clk     (clk),
      .a_we    (push),
      .a_addr  (stk_row),
      .a_wdata (wd[g]),
      .a_rdata (stk_rd[g]),
      .b_we    (dp_we_i && (dp_addr_i[0] == 1'(g))),
      .b_addr  (dp_addr_i[ADDR_W-1:1]),
      .b_wdata (dp_wdata_i),
      .b_rdata (dp_rd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= dp_addr_i[0];
  end

  assign dp_rdata_o = sel_q ? dp_rd[1] : dp_rd[0];

  rs_pcreg #(
    .PC_W    (PC_W),
    .DW      (DATA_W),
    .PSWH_W  (PSWH_W),
    .VEC_EXT (VEC_EXT),
    .VEC_TMR (VEC_TMR)
  ) u_pc (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op),
    .restore_i  (busy_q),
    .bank_set_i (bank_set_i),
    .bank_clr_i (bank_clr_i),
    .target_i   (target_i),
    .rd_lo_i    (stk_rd[0]),
    .rd_hi_i    (stk_rd[1]),
    .pc_q       (pc_o),
    .psw_q      (psw_hi_o)
  );

  assign sp_o = sp_q;

endmodule

// File: rtl/ret_stack_ctrl_chk.sv
module ret_stack_ctrl_chk #(
  parameter int PC_W   = 12,
  parameter int PSWH_W = 4,
  parameter int SP_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              call_i,
  input logic              irq_ext_i,
  input logic              irq_tmr_i,
  input logic              ret_i,
  input logic [PC_W-2:0]   target_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [PSWH_W-1:0] psw_hi_o,
  input logic [SP_W-1:0]   sp_o
);

  logic in_ret2;
  logic free;
  logic call_go;
  logic ret_go;

  assign free    = !in_ret2;
  assign call_go = free && call_i && !irq_ext_i && !irq_tmr_i;
  assign ret_go  = free && ret_i && !call_i && !irq_ext_i && !irq_tmr_i;

  always_ff @(posedge clk) begin
    if (rst) in_ret2 <= 1'b0;
    else     in_ret2 <= ret_go;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc_o == '0 && sp_o == '0 && psw_hi_o == '0));

  // R2
  call_load_chk: assert property (@(posedge clk) disable iff (rst)
    call_go |=> (sp_o == $past(sp_o) + SP_W'(1)) && (pc_o[PC_W-2:0] == $past(target_i)));

  // R4
  ext_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (free && irq_ext_i) |=> pc_o == PC_W'(3));

  // R5
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    ret_go |=> sp_o == $past(sp_o) - SP_W'(1));

  // R7
  ret_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    in_ret2 |=> $stable(sp_o));

  // R10
  psw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    free |=> $stable(psw_hi_o));

endmodule

bind ret_stack_ctrl ret_stack_ctrl_chk #(
  .PC_W   (PC_W),
  .PSWH_W (PSWH_W),
  .SP_W   (SP_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .call_i    (call_i),
  .irq_ext_i (irq_ext_i),
  .irq_tmr_i (irq_tmr_i),
  .ret_i     (ret_i),
  .target_i  (target_i),
  .pc_o      (pc_o),
  .psw_hi_o  (psw_hi_o),
  .sp_o      (sp_o)
);

// File: tb/ret_stack_ctrl_test.sv
`timescale 1ns/1ps
module ret_stack_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_r = 0, ext_r = 0, tmr_r = 0, ret_r = 0;
  logic [10:0] target_r = '0;
  logic [11:0] pcin_r = '0;
  logic [3:0]  pswin_r = '0;
  logic        bset_r = 0, bclr_r = 0;
  logic        dwe_r = 0;
  logic [5:0]  daddr_r = '0;
  logic [7:0]  dwd_r = '0;
  logic [7:0]  drd;
  logic [11:0] pc_o;
  logic [3:0]  psw_o;
  logic [2:0]  sp_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model
  logic [7:0]  m_mem [64];
  bit          m_known [64];
  logic [2:0]  m_sp = '0;
  logic [11:0] m_pc = '0;
  logic [3:0]  m_psw = '0;
  logic        m_bank = 0;
  logic        m_busy = 0;
  logic [7:0]  cap_lo = '0, cap_hi = '0;

  always #10 clk = ~clk;

  ret_stack_ctrl uut (
    .clk(clk), .rst(rst), .call_i(call_r), .irq_ext_i(ext_r), .irq_tmr_i(tmr_r),
    .ret_i(ret_r), .target_i(target_r), .pc_i(pcin_r), .psw_hi_i(pswin_r),
    .bank_set_i(bset_r), .bank_clr_i(bclr_r), .dp_we_i(dwe_r), .dp_addr_i(daddr_r),
    .dp_wdata_i(dwd_r), .dp_rdata_o(drd), .pc_o(pc_o), .psw_hi_o(psw_o), .sp_o(sp_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    call_r = 0; ext_r = 0; tmr_r = 0; ret_r = 0;
    bset_r = 0; bclr_r = 0; dwe_r = 0;
  endtask

  // One clock edge: advance the model, then compare at the falling edge.
  task automatic step(input string tg);
    int op;
    int a;
    bit rchk;
    bit was_busy;
    logic [7:0] erd;
    logic [2:0] nsp;
    string t;
    op = 0;
    if (!m_busy) begin
      if (ext_r) op = 1;
      else if (tmr_r) op = 2;
      else if (call_r) op = 3;
      else if (ret_r) op = 4;
    end
    a = int'(daddr_r);
    rchk = m_known[a];
    erd = m_mem[a];
    if (m_busy) begin
      m_pc = {cap_hi[3:0], cap_lo};
      m_psw = cap_hi[7:4];
    end
    if (op == 4) begin
      nsp = m_sp - 3'd1;
      cap_lo = m_mem[8 + 2 * int'(nsp)];
      cap_hi = m_mem[9 + 2 * int'(nsp)];
      m_sp = nsp;
    end
    if (dwe_r) begin
      m_mem[a] = dwd_r;
      m_known[a] = 1;
    end
    if (op >= 1 && op <= 3) begin
      m_mem[8 + 2 * int'(m_sp)] = pcin_r[7:0];
      m_mem[9 + 2 * int'(m_sp)] = {pswin_r, pcin_r[11:8]};
      m_known[8 + 2 * int'(m_sp)] = 1;
      m_known[9 + 2 * int'(m_sp)] = 1;
      m_pc = (op == 1) ? 12'd3 : (op == 2) ? 12'd7 : {m_bank, target_r};
      m_sp = m_sp + 3'd1;
    end
    if (bclr_r) m_bank = 0;
    else if (bset_r) m_bank = 1;
    was_busy = m_busy;
    m_busy = (op == 4);
    t = tg;
    if (t == "") begin
      if (op == 1 || op == 2) t = "R4";
      else if (op == 3) t = "R2";
      else if (op == 4 || was_busy) t = "R5";
      else t = "R10";
    end
    @(posedge clk);
    @(negedge clk);
    chk(pc_o == m_pc, t, "pc_o", int'(pc_o), int'(m_pc));
    chk(sp_o == m_sp, t, "sp_o", int'(sp_o), int'(m_sp));
    chk(psw_o == m_psw, (tg == "") ? "R10" : tg, "psw_hi_o", int'(psw_o), int'(m_psw));
    if (rchk)
      chk(drd == erd, (a >= 8 && a < 24) ? "R3" : "R9", "dp_rdata_o", int'(drd), int'(erd));
  endtask

  initial begin
    #4ms;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      m_mem[i] = '0;
      m_known[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state held under reset
    chk(pc_o == 12'd0, "R1", "pc_o", int'(pc_o), 0);
    chk(sp_o == 3'd0, "R1", "sp_o", int'(sp_o), 0);
    chk(psw_o == 4'd0, "R1", "psw_hi_o", int'(psw_o), 0);
    rst = 0;
    step("R1");

    // fill the RAM through the data port (R9)
    for (int i = 0; i < 64; i++) begin
      dwe_r = 1; daddr_r = 6'(i); dwd_r = 8'($urandom);
      step("R9");
    end
    clear_in();

    // R8: bank flag set, then set+clear together
    bset_r = 1; step("R8"); clear_in();
    call_r = 1; target_r = 11'h123; pcin_r = 12'hA5C; pswin_r = 4'h9; daddr_r = 6'd8;
    step("R8"); clear_in();
    chk(pc_o == 12'h923, "R8", "pc_o bank1", int'(pc_o), 12'h923);
    bset_r = 1; bclr_r = 1; step("R8"); clear_in();
    call_r = 1; target_r = 11'h456; pcin_r = 12'h3E1; pswin_r = 4'h6;
    step("R8"); clear_in();
    chk(pc_o == 12'h456, "R8", "pc_o bank0", int'(pc_o), 12'h456);
    ext_r = 1; pcin_r = 12'h111; step("R8"); clear_in();
    chk(pc_o == 12'd3, "R8", "ext ignores bank", int'(pc_o), 3);

    // R6: push past the top and pop back through zero
    bset_r = 1; step("R6"); clear_in();
    for (int i = 0; i < 8; i++) begin
      call_r = 1; target_r = 11'(i * 37); pcin_r = 12'(i * 291 + 5); pswin_r = 4'(i);
      daddr_r = 6'd22;
      step("R6"); clear_in();
    end
    for (int i = 0; i < 9; i++) begin
      ret_r = 1; daddr_r = 6'd23; step("R6"); clear_in();
      step("R6");
    end

    // R7: priority and ignored strobes during a return
    ext_r = 1; tmr_r = 1; call_r = 1; ret_r = 1; pcin_r = 12'h7B2;
    step("R7"); clear_in();
    chk(pc_o == 12'd3, "R7", "ext wins", int'(pc_o), 3);
    tmr_r = 1; call_r = 1; ret_r = 1; step("R7"); clear_in();
    chk(pc_o == 12'd7, "R7", "tmr wins", int'(pc_o), 7);
    ret_r = 1; step("R7"); clear_in();
    call_r = 1; ext_r = 1; ret_r = 1; step("R7"); clear_in();

    // R9: push and data write to the same byte, push kept
    dwe_r = 1; daddr_r = 6'(8 + 2 * int'(m_sp)); dwd_r = 8'h5A;
    call_r = 1; pcin_r = 12'hC3D; target_r = 11'h0AA;
    step("R9"); clear_in();
    step("R3");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      ext_r   = ($urandom_range(0, 15) == 0);
      tmr_r   = ($urandom_range(0, 15) == 0);
      call_r  = ($urandom_range(0, 5) == 0);
      ret_r   = ($urandom_range(0, 4) == 0);
      bset_r  = ($urandom_range(0, 15) == 0);
      bclr_r  = ($urandom_range(0, 15) == 0);
      dwe_r   = ($urandom_range(0, 2) == 0);
      daddr_r = 6'($urandom);
      dwd_r   = 8'($urandom);
      target_r = 11'($urandom);
      pcin_r  = 12'($urandom);
      pswin_r = 4'($urandom);
      step("");
    end
    clear_in();
    step("R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule